// File: doc/BRIEF.md
# Add/Subtract Flag ALU with Native-Width Carry

This block is the add/subtract slice of a processor's integer datapath. It takes two operands, an incoming carry, a 2-bit operation code, a 2-bit size code and a 3-bit step immediate. It performs add-with-carry, subtract-with-borrow, increment or decrement at 8, 16 or 32 bits. One clock later it presents the result together with six condition flags and a per-flag write-enable mask. The surrounding core uses the mask to merge the new flags into its flag register.

The adder never grows past the selected width. Carry and borrow come from an unsigned comparison of the same-width result against the first operand, with a tie broken by the incoming carry. This keeps the widest lane at exactly 32 bits.

Increment and decrement have their own flag rules. The step comes from a 3-bit immediate. These operations write flags only at byte size, and they never write carry.

Top module: `addsub_flag_alu`

## Requirements
- R1: A request presented with `in_valid` high appears on the outputs on the next rising clock edge, with `out_valid` high for exactly that cycle. When `in_valid` is low, `out_valid` falls and result, flags and mask hold their previous values.
- R2: Operation code 00 (add with carry) yields r = a + b + cin at the selected width. Carry (flag bit 0) is 1 exactly when the unsigned sum does not fit that width: r < a, or r == a with cin = 1.
- R3: Operation code 01 (subtract with borrow) yields r = a − b − cin at the selected width. Carry is 1 exactly when b + cin exceeds a as unsigned numbers: r > a, or r == a with cin = 1.
- R4: Overflow (flag bit 2) is 1 exactly when the two's-complement result of the operation is out of range at the selected width.
- R5: Flag bit 1 (N) is 0 after add and increment and 1 after subtract and decrement, whenever it is written.
- R6: Half-carry (flag bit 3) is bit 4 of a XOR b XOR r. It is never written (mask bit 3 = 0) at 32-bit size.
- R7: Size code 00 selects 8 bits, 01 selects 16 bits, 10 and 11 select 32 bits. Result bits above the selected width are 0. Zero (flag bit 4) is set when the result is 0 at that width, and sign (flag bit 5) is the result's top bit at that width.
- R8: Operation codes 10 (increment) and 11 (decrement) add or subtract a step with cin ignored. At 8-bit size they write N, V, H, Z and S. At 16 and 32 bits they write no flag (mask all 0).
- R9: Increment and decrement never write carry: mask bit 0 is 0 for both at every size.
- R10: The increment/decrement step is the 3-bit immediate, with the code 000 meaning 8. The operand b is ignored by these operations.
- R11: Every flag bit whose mask bit is 0 reads as 0. Add and subtract write all six flags except as R6 states.
- R12: While `rst_n` is low at a rising edge, `out_valid`, result, flags and mask all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 add-carry, 01 sub-borrow, 10 increment, 11 decrement |
| size | input | 2 | 00 byte, 01 16-bit, 1x 32-bit |
| opnd_a | input | MAX_W (32) | First operand |
| opnd_b | input | MAX_W (32) | Second operand (add/subtract only) |
| carry_in | input | 1 | Incoming carry/borrow (add/subtract only) |
| step_imm | input | 3 | Increment/decrement step, 000 = 8 |
| out_valid | output | 1 | Result valid |
| result | output | MAX_W (32) | Result, zero above the selected width |
| flag_out | output | 6 | {S,Z,H,V,N,C} at bits 5..0 |
| flag_we | output | 6 | Write-enable per flag, same bit layout |

## Verification
The bench aims at the tie case of the compare-based carry, where the result equals the first operand. This happens with b of all ones plus carry-in when adding, and the same when subtracting. A design that drops the carry-in tie term reports no carry there.

The bench also drives signed boundaries such as 0x80−1 and 0x7FFF+1. An overflow formula with the add and subtract terms swapped gets those wrong.

Other targets are a step immediate of 000, which a naive design treats as zero instead of 8, and increment/decrement at wide sizes, where a wrong mask would raise write-enables. Byte operations with garbage in the upper operand bits expose size-selection slips, and idle cycles expose outputs that fail to hold.

// File: rtl/addsub_alu_pkg.sv
// Package: shared encodings for the add/subtract flag ALU.
// Assumes flag bit positions are decoded by the flag register outside the block.
package addsub_alu_pkg;
    localparam int BYTE_W = 8;
    localparam int FLAG_N_BITS = 6;

    // flag bit positions (decoded by the neighbouring flag register)
    localparam int FL_C = 0;
    localparam int FL_N = 1;
    localparam int FL_V = 2;
    localparam int FL_H = 3;
    localparam int FL_Z = 4;
    localparam int FL_S = 5;

    typedef enum logic [1:0] {
        OP_ADC = 2'b00,
        OP_SBC = 2'b01,
        OP_INC = 2'b10,
        OP_DEC = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic v;
        logic n;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/addsub_lane.sv
// Module: one fixed-width add/subtract lane.
// Computes r = a +/- b +/- cin at exactly W bits; carry is derived by
// comparing r against a, so no extra adder bit is needed.
// Assumes W >= 5 so that bit 4 exists for half-carry.
module addsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c,
    output logic         v,
    output logic         h,
    output logic         z,
    output logic         s
);
    logic [W-1:0] cin_w;
    logic [W-1:0] x_ar;
    logic [W-1:0] x_br;
    logic [W-1:0] x_ab;

    // purpose: widen carry-in and form the native-width result
    always_comb begin
        cin_w = {{(W-1){1'b0}}, cin};
        r     = sub ? (a - b - cin_w) : (a + b + cin_w);
    end

    // purpose: derive all lane flags from operands and result
    always_comb begin
        x_ar = a ^ r;
        x_br = b ^ r;
        x_ab = a ^ b;
        if (sub) begin
            c = (r > a) || ((r == a) && cin);
            v = x_ab[W-1] & x_ar[W-1];
        end else begin
            c = (r < a) || ((r == a) && cin);
            v = x_ar[W-1] & x_br[W-1];
        end
        h = x_ab[4] ^ r[4];
        z = (r == '0);
        s = r[W-1];
    end
endmodule

// File: rtl/addsub_flag_mask.sv
// Module: flag write-enable mask for one request.
// Add/subtract write all flags except half-carry at the widest size;
// increment/decrement write N,V,H,Z,S only at byte size and never carry.
module addsub_flag_mask
    import addsub_alu_pkg::*;
#(
    parameter int NUM_LANES = 3
) (
    input  alu_op_e                        op,
    input  logic [$clog2(NUM_LANES+1)-1:0] lane_idx,
    output logic [FLAG_N_BITS-1:0]         we
);
    logic is_step;
    logic is_byte;
    logic is_widest;

    // purpose: classify the request
    always_comb begin
        is_step   = (op == OP_INC) || (op == OP_DEC);
        is_byte   = (lane_idx == '0);
        is_widest = (32'(lane_idx) == NUM_LANES - 1);
    end

    // purpose: build the mask
    always_comb begin
        we = '0;
        if (!is_step) begin
            we       = '1;
            we[FL_H] = !is_widest;
        end else if (is_byte) begin
            we       = '1;
            we[FL_C] = 1'b0;
        end
    end
endmodule

// File: rtl/addsub_flag_alu.sv
// Module: top of the add/subtract flag ALU.
// One register stage: a request sampled with in_valid appears one cycle later.
// Generates one lane per supported width (8, 16, ... MAX_W) and selects by size.
// Assumes MAX_W is 8 times a power of two; size codes beyond the widest clamp.
module addsub_flag_alu
    import addsub_alu_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             op,
    input  logic [1:0]             size,
    input  logic [MAX_W-1:0]       opnd_a,
    input  logic [MAX_W-1:0]       opnd_b,
    input  logic                   carry_in,
    input  logic [2:0]             step_imm,
    output logic                   out_valid,
    output logic [MAX_W-1:0]       result,
    output logic [FLAG_N_BITS-1:0] flag_out,
    output logic [FLAG_N_BITS-1:0] flag_we
);
    localparam int NUM_LANES = $clog2(MAX_W / BYTE_W) + 1;
    localparam int IDX_W     = $clog2(NUM_LANES + 1);

    alu_op_e          op_e;
    logic             is_step;
    logic             is_sub;
    logic [MAX_W-1:0] b_eff;
    logic             cin_eff;
    logic [IDX_W-1:0] lane_idx;

    logic [MAX_W-1:0] lane_r   [NUM_LANES];
    alu_flags_t       lane_f   [NUM_LANES];
    logic [FLAG_N_BITS-1:0] we_c;
    alu_flags_t       sel_f;
    logic [MAX_W-1:0] sel_r;

    // purpose: decode op and form the effective second operand
    always_comb begin
        op_e    = alu_op_e'(op);
        is_step = (op_e == OP_INC) || (op_e == OP_DEC);
        is_sub  = (op_e == OP_SBC) || (op_e == OP_DEC);
        cin_eff = is_step ? 1'b0 : carry_in;
        if (is_step)
            b_eff = (step_imm == 3'd0) ? MAX_W'(8) : MAX_W'(step_imm);
        else
            b_eff = opnd_b;
    end

    // purpose: map size code to lane index, clamped to the widest lane
    always_comb begin
        if (32'(size) >= NUM_LANES - 1)
            lane_idx = IDX_W'(NUM_LANES - 1);
        else
            lane_idx = IDX_W'(size);
    end

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        localparam int LW = BYTE_W << gi;
        logic [LW-1:0] r_n;
        logic c_n, v_n, h_n, z_n, s_n;

        addsub_lane #(.W(LW)) u_lane (
            .a   (opnd_a[LW-1:0]),
            .b   (b_eff[LW-1:0]),
            .cin (cin_eff),
            .sub (is_sub),
            .r   (r_n),
            .c   (c_n),
            .v   (v_n),
            .h   (h_n),
            .z   (z_n),
            .s   (s_n)
        );

        // purpose: zero-extend the lane result and pack its flags
        always_comb begin
            lane_r[gi] = MAX_W'(r_n);
            lane_f[gi] = '{s: s_n, z: z_n, h: h_n, v: v_n, n: is_sub, c: c_n};
        end
    end

    addsub_flag_mask #(.NUM_LANES(NUM_LANES)) u_mask (
        .op       (op_e),
        .lane_idx (lane_idx),
        .we       (we_c)
    );

    // purpose: pick the lane for the requested size
    always_comb begin
        sel_r = lane_r[0];
        sel_f = lane_f[0];
        for (int li = 1; li < NUM_LANES; li++) begin
            if (32'(lane_idx) == li) begin
                sel_r = lane_r[li];
                sel_f = lane_f[li];
            end
        end
    end

    // purpose: output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_out  <= '0;
            flag_we   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= sel_r;
                flag_out <= sel_f & we_c;
                flag_we  <= we_c;
            end
        end
    end
endmodule

// File: rtl/addsub_flag_alu_chk.sv
// Module: assertion checker bound to addsub_flag_alu.
// Observes ports only; relates requests to the registered response.
module addsub_flag_alu_chk
    import addsub_alu_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [1:0]             op,
    input logic [1:0]             size,
    input logic [MAX_W-1:0]       opnd_a,
    input logic [MAX_W-1:0]       opnd_b,
    input logic                   carry_in,
    input logic [2:0]             step_imm,
    input logic                   out_valid,
    input logic [MAX_W-1:0]       result,
    input logic [FLAG_N_BITS-1:0] flag_out,
    input logic [FLAG_N_BITS-1:0] flag_we
);
    logic req_step;
    logic req_sub;
    always_comb begin
        req_step = (op == OP_INC) || (op == OP_DEC);
        req_sub  = (op == OP_SBC) || (op == OP_DEC);
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_out)));
    p_n_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !req_step) |=> (flag_out[FL_N] == $past(req_sub)));
    p_no_h_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size[1]) |=> !flag_we[FL_H]);
    p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'b00) |=> (result[MAX_W-1:8] == '0));
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we[FL_Z]) |-> (flag_out[FL_Z] == (result == '0)));
    p_step_wide_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_step && size != 2'b00) |=> (flag_we == '0));
    p_step_no_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_step) |=> !flag_we[FL_C]);
    p_masked_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((flag_out & ~flag_we) == '0));
endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.MAX_W(MAX_W)) u_chk (.*);

// File: tb/sim_addsub_flag_alu.sv
`timescale 1ns/1ps
module sim_addsub_flag_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op;
    logic [1:0]  size;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        carry_in;
    logic [2:0]  step_imm;
    logic        out_valid;
    logic [31:0] result;
    logic [5:0]  flag_out;
    logic [5:0]  flag_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected state after the next edge
    logic        e_valid;
    logic [31:0] e_res;
    logic [5:0]  e_flags;
    logic [5:0]  e_we;
    string       e_tag;

    always #2 clk = ~clk;

    addsub_flag_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .step_imm(step_imm),
        .out_valid(out_valid), .result(result), .flag_out(flag_out), .flag_we(flag_we)
    );

    // behavioural reference using wide integer arithmetic
    task automatic model(input logic [1:0] o, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] b, input logic ci, input logic [2:0] im);
        int w;
        longint m, ua, ub, full, sa, sb, sfull, lo, hi, r;
        logic c, v, h, z, s, n;
        bit step, sub;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        step = o[1];
        sub = o[0];
        ua = longint'(a) & m;
        ub = step ? ((im == 3'd0) ? 8 : longint'(im)) : (longint'(b) & m);
        if (step) ci = 1'b0;
        full = sub ? (ua - ub - longint'(ci)) : (ua + ub + longint'(ci));
        r = full & m;
        c = sub ? (ua < ub + longint'(ci)) : (full > m);
        sa = (ua ^ (longint'(1) << (w-1))) - (longint'(1) << (w-1));
        sb = (ub ^ (longint'(1) << (w-1))) - (longint'(1) << (w-1));
        sfull = sub ? (sa - sb - longint'(ci)) : (sa + sb + longint'(ci));
        lo = -(longint'(1) << (w-1));
        hi = (longint'(1) << (w-1)) - 1;
        v = (sfull < lo) || (sfull > hi);
        h = ((ua ^ ub ^ r) >> 4) & 1;
        z = (r == 0);
        s = (r >> (w-1)) & 1;
        n = sub;
        if (!step)          e_we = (w == 32) ? 6'b110111 : 6'b111111;
        else if (w == 8)    e_we = 6'b111110;
        else                e_we = 6'b000000;
        e_res = 32'(r);
        e_flags = {s, z, h, v, n, c} & e_we;
    endtask

    task automatic check_now();
        checks++;
        if (out_valid !== e_valid || result !== e_res || flag_out !== e_flags || flag_we !== e_we) begin
            failures++;
            $display("FAIL %s: got v=%0b r=%h f=%b we=%b expected v=%0b r=%h f=%b we=%b",
                     e_tag, out_valid, result, flag_out, flag_we, e_valid, e_res, e_flags, e_we);
        end
    endtask

    // drive one request at the negedge, check it at the following negedge
    task automatic req(input logic [1:0] o, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input logic [2:0] im, input string tag);
        in_valid = 1'b1; op = o; size = sz; opnd_a = a; opnd_b = b; carry_in = ci; step_imm = im;
        model(o, sz, a, b, ci, im);
        e_valid = 1'b1;
        e_tag = tag;
        @(negedge clk);
        check_now();
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        opnd_a = $urandom; opnd_b = $urandom; op = 2'($urandom); size = 2'($urandom);
        e_valid = 1'b0;
        e_tag = tag;
        @(negedge clk);
        check_now();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hang expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; op = 2'b00; size = 2'b00;
        opnd_a = 32'h12; opnd_b = 32'h34; carry_in = 1'b1; step_imm = 3'd0;
        repeat (3) @(negedge clk);
        e_valid = 1'b0; e_res = '0; e_flags = '0; e_we = '0; e_tag = "R12 reset";
        check_now();
        rst_n = 1'b1;
        // R2 add with carry
        req(2'b00, 2'b00, 32'h0000_0012, 32'h0000_0034, 1'b0, 3'd0, "R2 byte add");
        req(2'b00, 2'b00, 32'h0000_00F0, 32'h0000_0020, 1'b0, 3'd0, "R2 byte carry");
        req(2'b00, 2'b00, 32'h0000_005A, 32'h0000_00FF, 1'b1, 3'd0, "R2 tie r==a with cin");
        req(2'b00, 2'b10, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 3'd0, "R2 32-bit wrap");
        req(2'b00, 2'b01, 32'h0000_1234, 32'h0000_FFFF, 1'b1, 3'd0, "R2 16-bit tie");
        // R3 subtract with borrow
        req(2'b01, 2'b00, 32'h0000_0010, 32'h0000_0020, 1'b0, 3'd0, "R3 byte borrow");
        req(2'b01, 2'b00, 32'h0000_0077, 32'h0000_00FF, 1'b1, 3'd0, "R3 tie r==a with cin");
        req(2'b01, 2'b10, 32'h1234_5678, 32'h1234_5678, 1'b0, 3'd0, "R3 R7 zero result");
        // R4 overflow
        req(2'b00, 2'b01, 32'h0000_7FFF, 32'h0000_0001, 1'b0, 3'd0, "R4 16-bit add overflow");
        req(2'b01, 2'b00, 32'h0000_0080, 32'h0000_0001, 1'b0, 3'd0, "R4 byte sub overflow");
        req(2'b01, 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd0, "R4 32-bit sub overflow");
        // R6 half-carry masked at 32 bits, R7 upper bits and width
        req(2'b00, 2'b10, 32'h0000_000F, 32'h0000_0001, 1'b0, 3'd0, "R6 no H at 32-bit");
        req(2'b00, 2'b00, 32'hABCD_EF0F, 32'h9876_5401, 1'b0, 3'd0, "R6 R7 byte H and upper zero");
        req(2'b00, 2'b01, 32'hFFFF_8000, 32'h0000_0000, 1'b0, 3'd0, "R7 16-bit sign");
        req(2'b00, 2'b11, 32'h8000_0000, 32'h0000_0000, 1'b0, 3'd0, "R7 size 11 is 32-bit");
        // R8 R9 R10 increment and decrement
        req(2'b10, 2'b00, 32'h0000_0010, 32'hFFFF_FFFF, 1'b1, 3'd0, "R10 step 000 is 8");
        req(2'b10, 2'b00, 32'h0000_00FF, 32'h0000_0000, 1'b1, 3'd1, "R9 inc byte wrap no carry");
        req(2'b11, 2'b00, 32'h0000_0080, 32'h0000_0000, 1'b0, 3'd1, "R8 dec byte overflow");
        req(2'b11, 2'b00, 32'h0000_0003, 32'h0000_0000, 1'b1, 3'd3, "R5 R8 dec byte zero");
        req(2'b10, 2'b01, 32'h0000_FFFF, 32'h0000_0000, 1'b0, 3'd1, "R8 inc 16-bit no flags");
        req(2'b11, 2'b10, 32'h0000_0000, 32'h0000_0000, 1'b0, 3'd0, "R8 R10 dec 32-bit by 8");
        // R1 hold while idle
        idle("R1 idle hold");
        idle("R1 idle hold 2");
        req(2'b01, 2'b01, 32'h0000_0100, 32'h0000_0001, 1'b1, 3'd0, "R1 after idle");
        // R11 mixed patterns
        for (int i = 0; i < 300; i++) begin
            if ((i % 7) == 3)
                idle("R1 random idle");
            else
                req(2'($urandom), 2'($urandom), $urandom, $urandom, 1'($urandom), 3'($urandom),
                    "R11 random");
        end
        // R12 reset mid-stream
        in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        e_valid = 1'b0; e_res = '0; e_flags = '0; e_we = '0; e_tag = "R12 reset mid-run";
        check_now();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule